// File: doc/BRIEF.md
# Calendar Time Counter with Stop Control

This block keeps calendar time: seconds, minutes, hours, weekday, day of month, month and a two-digit year that covers 2000 to 2099. A parameterised prescaler divides an oscillator pulse stream into a one-second tick. Each tick advances the seconds field. A carry ripples upward through minutes, hours and the date fields. Month lengths and the leap day of February are honoured.

Software reaches every field through a small register bus. Each field sits in its own 32-bit word, with the year first. A control word carries a stop flag. Software sets the flag before it loads a new time and clears it to start counting again. A write-permission input stands in for the unlock sequence, and writes take effect only while it is high. A three-bit debounce setting is kept as a plain read/write word. All read data comes straight from registers, so a value cannot change inside a single clock cycle.

Top module: `cal_counter`

## Requirements
- R1: After reset the fields read year 0, month 1, day 1, weekday 0, and 00:00:00. The control word reads 1 (stopped) and the debounce word reads 0.
- R2: While control bit 0 (address 0x20) is 1, no field advances and the prescaler is held at zero. Clearing the bit resumes counting, and the next second then takes a full PRESCALE pulses.
- R3: Field words are at 0x40 + 4*k, with k = 0 year, 1 month, 2 day of month, 3 weekday, 4 hour, 5 minute, 6 second. Each is writable and reads back zero-extended.
- R4: Seconds and minutes wrap from 59 to 0 and carry. Hours wrap from 23 to 0 and carry into the date.
- R5: On each day carry the weekday steps through 0 to 6 and then back to 0.
- R6: Day of month wraps to 1 after the month's last day: 30 for months 4, 6, 9 and 11, 31 for other months, and 29 for month 2 when year mod 4 is 0, else 28. Month wraps from 12 to 1 and carries into the year.
- R7: Year wraps from 99 to 0.
- R8: A bus write with the permission input low changes no register.
- R9: The debounce word at 0x2C stores bits 2:0 of write data and reads back only those bits.
- R10: With counting enabled, exactly one second elapses per PRESCALE oscillator pulses.
- R11: If a field write and a tick fall in the same cycle, the written field takes the written value. The other fields still advance from the carries of the old values.
- R12: Read data is a combinational function of the address and the registers. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_pulse | input | 1 | One-cycle oscillator pulse fed to the prescaler |
| wr_unlock | input | 1 | Write permission |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data |

## Verification
The main carry chain is driven by a table of loaded times. Each entry sits one second before a different boundary:
- a plain second step;
- a minute, hour or day carry;
- the end of a 30-day month and of a 31-day month;
- February in a leap year and in a common year;
- the year end, including the 99 to 0 wrap.

Each entry therefore isolates one comparison in the rollover logic. Directed tests follow the table:
- A write and a tick in the same cycle separate "write wins for its field" from "write blocks the whole carry".
- Single pulses before and after a stop period show that the prescaler counts and that it is cleared.
- Locked writes show that the permission input gates both the fields and the control word.

// File: rtl/cal_counter.sv
module cal_counter #(
  parameter int PRESCALE = 32768,
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          osc_pulse,
  input  logic          wr_unlock,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata
);
  localparam int PW = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] PRE_TOP = PW'(PRESCALE - 1);
  localparam logic [AW-1:0] A_CTL = AW'(8'h20);
  localparam logic [AW-1:0] A_DBN = AW'(8'h2C);
  localparam logic [AW-1:0] A_YR  = AW'(8'h40);
  localparam logic [AW-1:0] A_MON = AW'(8'h44);
  localparam logic [AW-1:0] A_DOM = AW'(8'h48);
  localparam logic [AW-1:0] A_DOW = AW'(8'h4C);
  localparam logic [AW-1:0] A_HR  = AW'(8'h50);
  localparam logic [AW-1:0] A_MIN = AW'(8'h54);
  localparam logic [AW-1:0] A_SEC = AW'(8'h58);

  logic [6:0] yr_q;
  logic [3:0] mon_q;
  logic [4:0] dom_q, hr_q, mdays;
  logic [2:0] dow_q, dbn_q;
  logic [5:0] min_q, sec_q;
  logic       stop_q;
  logic [PW-1:0] pre_q;

  logic wr_ok, tick, c_min, c_hr, c_day, c_mon, c_yr;

  assign wr_ok = bus_we & wr_unlock;
  assign tick  = osc_pulse & ~stop_q & (pre_q == PRE_TOP);
  assign c_min = tick  & (sec_q >= 6'd59);
  assign c_hr  = c_min & (min_q >= 6'd59);
  assign c_day = c_hr  & (hr_q  >= 5'd23);
  assign c_mon = c_day & (dom_q >= mdays);
  assign c_yr  = c_mon & (mon_q >= 4'd12);

  always_comb begin
    case (mon_q)
      4'd2:                       mdays = (yr_q[1:0] == 2'd0) ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:    mdays = 5'd30;
      default:                    mdays = 5'd31;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (stop_q) begin
      pre_q <= '0;
    end else if (osc_pulse) begin
      pre_q <= (pre_q == PRE_TOP) ? '0 : pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stop_q <= 1'b1;
      dbn_q  <= '0;
    end else if (wr_ok) begin
      if (bus_addr == A_CTL) stop_q <= bus_wdata[0];
      if (bus_addr == A_DBN) dbn_q  <= bus_wdata[2:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                        sec_q <= '0;
    else if (wr_ok && bus_addr == A_SEC) sec_q <= bus_wdata[5:0];
    else if (tick)                     sec_q <= (sec_q >= 6'd59) ? 6'd0 : sec_q + 6'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                        min_q <= '0;
    else if (wr_ok && bus_addr == A_MIN) min_q <= bus_wdata[5:0];
    else if (c_min)                    min_q <= (min_q >= 6'd59) ? 6'd0 : min_q + 6'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                        hr_q <= '0;
    else if (wr_ok && bus_addr == A_HR) hr_q <= bus_wdata[4:0];
    else if (c_hr)                     hr_q <= (hr_q >= 5'd23) ? 5'd0 : hr_q + 5'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                        dow_q <= '0;
    else if (wr_ok && bus_addr == A_DOW) dow_q <= bus_wdata[2:0];
    else if (c_day)                    dow_q <= (dow_q >= 3'd6) ? 3'd0 : dow_q + 3'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                        dom_q <= 5'd1;
    else if (wr_ok && bus_addr == A_DOM) dom_q <= bus_wdata[4:0];
    else if (c_day)                    dom_q <= (dom_q >= mdays) ? 5'd1 : dom_q + 5'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                        mon_q <= 4'd1;
    else if (wr_ok && bus_addr == A_MON) mon_q <= bus_wdata[3:0];
    else if (c_mon)                    mon_q <= (mon_q >= 4'd12) ? 4'd1 : mon_q + 4'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                        yr_q <= '0;
    else if (wr_ok && bus_addr == A_YR) yr_q <= bus_wdata[6:0];
    else if (c_yr)                     yr_q <= (yr_q >= 7'd99) ? 7'd0 : yr_q + 7'd1;
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTL: bus_rdata = DW'(stop_q);
      A_DBN: bus_rdata = DW'(dbn_q);
      A_YR:  bus_rdata = DW'(yr_q);
      A_MON: bus_rdata = DW'(mon_q);
      A_DOM: bus_rdata = DW'(dom_q);
      A_DOW: bus_rdata = DW'(dow_q);
      A_HR:  bus_rdata = DW'(hr_q);
      A_MIN: bus_rdata = DW'(min_q);
      A_SEC: bus_rdata = DW'(sec_q);
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/cal_counter_chk.sv
module cal_counter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       stop,
  input logic       wr_any,
  input logic       c_day,
  input logic       c_mon,
  input logic [5:0] sec,
  input logic [5:0] min,
  input logic [4:0] hr,
  input logic [2:0] dow,
  input logic [3:0] mon
);
  p_stop_no_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stop |-> !tick);
  p_stop_freeze_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !wr_any) |=> ($stable(sec) && $stable(min) && $stable(hr)));
  p_sec_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && sec == 6'd59 && !wr_any) |=> sec == 6'd0);
  p_hr_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (c_day && hr == 5'd23 && !wr_any) |=> hr == 5'd0);
  p_dow_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (c_day && dow == 3'd6 && !wr_any) |=> dow == 3'd0);
  p_mon_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (c_mon && mon == 4'd12 && !wr_any) |=> mon == 4'd1);
  p_sec_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && sec < 6'd59 && !wr_any) |=> sec == $past(sec) + 6'd1);
endmodule

bind cal_counter cal_counter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .stop(stop_q), .wr_any(wr_ok),
  .c_day(c_day), .c_mon(c_mon), .sec(sec_q), .min(min_q), .hr(hr_q),
  .dow(dow_q), .mon(mon_q)
);

// File: tb/cal_counter_tb_top.sv
`timescale 1ns/1ps
module cal_counter_tb_top;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam int PS = 2;
  localparam logic [7:0] A_CTL = 8'h20, A_DBN = 8'h2C, A_FLD = 8'h40;
  localparam logic [7:0] A_MIN = 8'h54, A_SEC = 8'h58;

  localparam int NV = 13;
  localparam logic [111:0] VEC [NV] = '{
    {56'h17030F030A141E, 56'h17030F030A141F},
    {56'h17030F030A143B, 56'h17030F030A1500},
    {56'h17030F030A3B3B, 56'h17030F030B0000},
    {56'h17030F03173B3B, 56'h17031004000000},
    {56'h17041E06173B3B, 56'h17050100000000},
    {56'h18021C01173B3B, 56'h18021D02000000},
    {56'h17021C01173B3B, 56'h17030102000000},
    {56'h18021D03173B3B, 56'h18030104000000},
    {56'h170C1F00173B3B, 56'h18010101000000},
    {56'h630C1F05173B3B, 56'h00010106000000},
    {56'h17011E02173B3B, 56'h17011F03000000},
    {56'h17011F03173B3B, 56'h17020104000000},
    {56'h17091E04173B3B, 56'h170A0105000000}
  };

  logic clk = 1'b0, rst_n = 1'b0, osc_pulse = 1'b0, wr_unlock = 1'b0, bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cal_counter #(.PRESCALE(PS), .AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .osc_pulse(osc_pulse), .wr_unlock(wr_unlock),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic unl = 1'b1);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1; wr_unlock = unl;
    @(negedge clk);
    bus_we = 1'b0; wr_unlock = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic osc(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); osc_pulse = 1'b1;
      @(negedge clk); osc_pulse = 1'b0;
    end
  endtask

  task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d", what, got, exp);
    end
  endtask

  task automatic rchk(input string what, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(what, d, exp);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rchk("R1 year", A_FLD, 0);
    rchk("R1 month", A_FLD + 8'h4, 1);
    rchk("R1 day", A_FLD + 8'h8, 1);
    rchk("R1 weekday", A_FLD + 8'hC, 0);
    rchk("R1 second", A_SEC, 0);
    rchk("R1 control", A_CTL, 1);
    rchk("R1 debounce", A_DBN, 0);

    // R3 R4 R5 R6 R7 table of one-second-before-boundary loads
    for (int v = 0; v < NV; v++) begin
      wr(A_CTL, 1);
      for (int k = 0; k < 7; k++)
        wr(A_FLD + 8'(4 * k), 32'(VEC[v][111 - 8*k -: 8]));
      wr(A_CTL, 0);
      osc(PS);
      for (int k = 0; k < 7; k++) begin
        logic [31:0] d;
        rd(A_FLD + 8'(4 * k), d);
        chk($sformatf("R3 R4 R5 R6 R7 vector %0d field %0d", v, k), d, 32'(VEC[v][55 - 8*k -: 8]));
      end
    end

    // R11 write and tick in same cycle
    wr(A_MIN, 5);
    wr(A_SEC, 59);
    osc(1);
    @(negedge clk);
    osc_pulse = 1'b1; bus_we = 1'b1; wr_unlock = 1'b1; bus_addr = A_SEC; bus_wdata = 40;
    @(negedge clk);
    osc_pulse = 1'b0; bus_we = 1'b0; wr_unlock = 1'b0;
    rchk("R11 written field wins", A_SEC, 40);
    rchk("R11 other field carries", A_MIN, 6);

    // R10 prescaler
    osc(1);
    rchk("R10 half second", A_SEC, 40);
    osc(1);
    rchk("R10 full second", A_SEC, 41);

    // R2 stop
    wr(A_CTL, 1);
    osc(6);
    rchk("R2 frozen", A_SEC, 41);
    rchk("R2 control set", A_CTL, 1);
    osc(1);
    wr(A_CTL, 0);
    osc(1);
    rchk("R2 prescaler cleared", A_SEC, 41);
    osc(1);
    rchk("R2 resumed", A_SEC, 42);

    // R8 locked writes
    wr(A_SEC, 7, 1'b0);
    rchk("R8 locked field", A_SEC, 42);
    wr(A_CTL, 1, 1'b0);
    osc(PS);
    rchk("R8 locked control", A_SEC, 43);

    // R9 debounce
    wr(A_DBN, 32'hFF);
    rchk("R9 debounce", A_DBN, 7);

    // R12 unmapped
    rchk("R12 unmapped", 8'h30, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule